// File: doc/BRIEF.md
# Pulse-Swallowing Frequency Trimmer

This block sits between a free-running reference and a fixed-ratio binary divider chain. Instead of tuning the oscillator, it trims the average divided frequency by deleting a programmable number of reference pulses in every adjustment cycle. The reference is expected to run at or a little above the nominal rate, so correction only ever removes pulses. The reference arrives as a single-cycle enable pulse stream in one clock domain. A per-device trim word, held in external nonvolatile storage, is presented as a static input.

An adjustment cycle is one full turn of the divider chain. With the default 20-stage chain, removing one pulse per cycle moves the average output frequency by about 1 ppm, and a 7-bit word gives about 128 ppm of range. The controller is a three-state machine:

- **ARM** waits for the first pulse of a cycle and captures the trim word there.
- **INHIBIT** swallows the remaining pulses of the captured count.
- **PASS** forwards every pulse to the divider until the chain wraps.

The transitions are:

- ARM→PASS on a pulse when the word is 0 (the pulse passes) or 1 (the pulse is swallowed).
- ARM→INHIBIT on a pulse when the word is 2 or more.
- INHIBIT→PASS on the pulse that completes the swallowed count.
- PASS→ARM on the pulse that wraps the full chain.
- Reset returns to ARM from any state.

The lower stages give a seconds tick, and the full chain gives a cycle-wrap strobe.

Top module: `pulse_swallow_trim`

## Requirements
- R1: Each forwarded reference pulse advances the divider count by exactly one (modulo 2^CHAIN_W) and raises `pass_o` for one cycle. Both outputs update on the clock edge that samples the pulse.
- R2: A swallowed pulse leaves `count_o` unchanged and keeps `pass_o` low.
- R3: In each adjustment cycle, the first N reference pulses are swallowed back to back and every later pulse is forwarded until the chain wraps. N is the captured trim word, so a cycle consumes 2^CHAIN_W + N reference pulses.
- R4: The trim word is captured only on the first pulse of an adjustment cycle. A change made during a cycle does not alter that cycle's length and takes effect in the following cycle.
- R5: A trim word of 0 forwards every pulse, so a cycle consumes exactly 2^CHAIN_W pulses.
- R6: The largest trim word (2^TRIM_W − 1, which is 127 by default) swallows that many pulses in the cycle.
- R7: `sec_tick_o` is high for one cycle exactly when a forwarded pulse wraps the lower SEC_W divider stages to zero.
- R8: `cyc_wrap_o` is high for one cycle exactly when a forwarded pulse wraps the full chain, and `count_o` then reads zero.
- R9: A synchronous reset clears the divider, the swallow counter and the captured word, and drives all strobes low. The first pulse after reset starts a fresh cycle using the trim word present at that pulse.
- R10: With no reference pulse, `pass_o` stays low and `count_o` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Single clock for all state |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_pulse_i | input | 1 | One-cycle enable per reference oscillator pulse |
| trim_word_i | input | TRIM_W | Number of pulses to swallow per adjustment cycle |
| pass_o | output | 1 | Registered strobe for a pulse forwarded into the divider |
| count_o | output | CHAIN_W | Divider chain count |
| sec_tick_o | output | 1 | One-cycle strobe on wrap of the lower SEC_W stages |
| cyc_wrap_o | output | 1 | One-cycle strobe on wrap of the full chain |

## Verification
On every cycle, the embedded assertions check four step properties of the counter:

- a forwarded pulse moves the count by one;
- a swallowed pulse or an idle cycle leaves it still;
- each strobe lines up with a zeroed count field;
- the captured word only changes in ARM and always bounds the swallow counter.

The length of a whole adjustment cycle cannot be seen from any single step, so only the bench scenarios show it. The same holds for swallowing the exact trim count, for a mid-cycle trim change deferring to the next cycle, and for a clean restart after a mid-cycle reset. The bench counts reference pulses between wraps for those.

// File: rtl/ptrim_pkg.sv
package ptrim_pkg;

    typedef enum logic [1:0] {
        ST_ARM     = 2'd0,
        ST_INHIBIT = 2'd1,
        ST_PASS    = 2'd2
    } trim_state_e;

endpackage

// File: rtl/ptrim_gate.sv
module ptrim_gate
    import ptrim_pkg::*;
#(
    parameter int TRIM_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ref_pulse_i,
    input  logic [TRIM_W-1:0] trim_word_i,
    input  logic              chain_full_i,
    output logic              pass_en_o
);

    localparam logic [TRIM_W-1:0] ONE = TRIM_W'(1);

    trim_state_e       state_q, state_d;
    logic [TRIM_W-1:0] inh_cnt_q, inh_cnt_d;
    logic [TRIM_W-1:0] trim_q, trim_d;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        inh_cnt_d = inh_cnt_q;
        trim_d    = trim_q;
        unique case (state_q)
            ST_ARM: begin
                if (ref_pulse_i) begin
                    trim_d = trim_word_i;
                    if (trim_word_i == '0) begin
                        inh_cnt_d = '0;
                        state_d   = ST_PASS;
                    end else begin
                        inh_cnt_d = ONE;
                        state_d   = (trim_word_i == ONE) ? ST_PASS : ST_INHIBIT;
                    end
                end
            end
            ST_INHIBIT: begin
                if (ref_pulse_i) begin
                    inh_cnt_d = inh_cnt_q + ONE;
                    if (inh_cnt_q + ONE == trim_q) begin
                        state_d = ST_PASS;
                    end
                end
            end
            ST_PASS: begin
                if (ref_pulse_i && chain_full_i) begin
                    inh_cnt_d = '0;
                    state_d   = ST_ARM;
                end
            end
            default: begin
                inh_cnt_d = '0;
                state_d   = ST_ARM;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= ST_ARM;
            inh_cnt_q <= '0;
            trim_q    <= '0;
        end else begin
            state_q   <= state_d;
            inh_cnt_q <= inh_cnt_d;
            trim_q    <= trim_d;
        end
    end

    // outputs
    always_comb begin
        pass_en_o = 1'b0;
        unique case (state_q)
            ST_ARM:     pass_en_o = ref_pulse_i && (trim_word_i == '0);
            ST_INHIBIT: pass_en_o = 1'b0;
            ST_PASS:    pass_en_o = ref_pulse_i;
            default:    pass_en_o = 1'b0;
        endcase
    end

    // R3: swallow counter never exceeds the captured word
    a_r3_inh_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_ARM) |-> (inh_cnt_q <= trim_q));

    // R4: captured word only changes when leaving ARM
    a_r4_trim_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_ARM) |=> $stable(trim_q));

endmodule

// File: rtl/ptrim_chain.sv
module ptrim_chain #(
    parameter int CHAIN_W = 20,
    parameter int SEC_W   = 15
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               step_i,
    output logic [CHAIN_W-1:0] count_o,
    output logic               full_o,
    output logic               tick_o,
    output logic               wrap_o
);

    logic [CHAIN_W-1:0] stage_q;
    logic [CHAIN_W:0]   carry;
    logic               tick_q, wrap_q;

    assign carry[0] = step_i;

    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                stage_q[g] <= 1'b0;
            end else if (carry[g]) begin
                stage_q[g] <= ~stage_q[g];
            end
        end
        assign carry[g+1] = carry[g] & stage_q[g];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tick_q <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            tick_q <= carry[SEC_W];
            wrap_q <= carry[CHAIN_W];
        end
    end

    assign count_o = stage_q;
    assign full_o  = &stage_q;
    assign tick_o  = tick_q;
    assign wrap_o  = wrap_q;

    // R7: seconds tick coincides with a zeroed lower field
    a_r7_tick_align: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |-> (stage_q[SEC_W-1:0] == '0));

    // R8: cycle wrap coincides with a zeroed chain
    a_r8_wrap_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        wrap_o |-> (stage_q == '0));

endmodule

// File: rtl/pulse_swallow_trim.sv
module pulse_swallow_trim #(
    parameter int CHAIN_W = 20,
    parameter int SEC_W   = 15,
    parameter int TRIM_W  = 7
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ref_pulse_i,
    input  logic [TRIM_W-1:0]  trim_word_i,
    output logic               pass_o,
    output logic [CHAIN_W-1:0] count_o,
    output logic               sec_tick_o,
    output logic               cyc_wrap_o
);

    logic pass_en;
    logic chain_full;
    logic pass_q;

    ptrim_gate #(.TRIM_W(TRIM_W)) u_gate (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .ref_pulse_i  (ref_pulse_i),
        .trim_word_i  (trim_word_i),
        .chain_full_i (chain_full),
        .pass_en_o    (pass_en)
    );

    ptrim_chain #(.CHAIN_W(CHAIN_W), .SEC_W(SEC_W)) u_chain (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (pass_en),
        .count_o (count_o),
        .full_o  (chain_full),
        .tick_o  (sec_tick_o),
        .wrap_o  (cyc_wrap_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pass_q <= 1'b0;
        end else begin
            pass_q <= pass_en;
        end
    end

    assign pass_o = pass_q;

    // R1: forwarded pulse steps the count by one
    a_r1_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
        pass_en |=> (count_o == CHAIN_W'($past(count_o) + 1'b1)));

    // R2: swallowed pulse freezes the count
    a_r2_inhibit_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (ref_pulse_i && !pass_en) |=> ($stable(count_o) && !pass_o));

    // R10: idle cycle changes nothing
    a_r10_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !ref_pulse_i |=> (!pass_o && $stable(count_o)));

endmodule

// File: tb/pulse_swallow_trim_bench.sv
module pulse_swallow_trim_bench;

    localparam int CW   = 10;
    localparam int SW   = 5;
    localparam int TW   = 7;
    localparam int FULL = 1 << CW;
    localparam int SEC  = 1 << SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_p = 1'b0;
    logic [TW-1:0] trim = '0;
    logic          pass_o, sec_tick_o, cyc_wrap_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    pulse_swallow_trim #(.CHAIN_W(CW), .SEC_W(SW), .TRIM_W(TW)) u_pulse_swallow_trim (
        .clk_i       (clk),
        .rst_i       (rst),
        .ref_pulse_i (ref_p),
        .trim_word_i (trim),
        .pass_o      (pass_o),
        .count_o     (count_o),
        .sec_tick_o  (sec_tick_o),
        .cyc_wrap_o  (cyc_wrap_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One adjustment cycle from ARM; returns the reference pulses consumed.
    task automatic run_cycle(input int t0, input int chg_at, input int t1,
                             input int gap, input string req, output int taken);
        int  cap = t0;
        int  k = 0;
        bit  done = 0;
        bit  ep, et, ew;
        trim = TW'(t0);
        while (!done && k < FULL + 200) begin
            @(negedge clk);
            if (k == chg_at) trim = TW'(t1);
            ref_p = 1'b1;
            @(negedge clk);
            ref_p = 1'b0;
            ep = (k >= cap);
            if (ep) exp_cnt = (exp_cnt + 1) % FULL;
            et = ep && (exp_cnt % SEC == 0);
            ew = ep && (exp_cnt == 0);
            if (ep) begin
                chk(pass_o == 1'b1, "R1 pass", pass_o, 1);
                chk(int'(count_o) == exp_cnt, "R1 count", count_o, exp_cnt);
            end else begin
                chk(pass_o == 1'b0, "R2 pass", pass_o, 0);
                chk(int'(count_o) == exp_cnt, "R2 count", count_o, exp_cnt);
            end
            chk(sec_tick_o == et, "R7 tick", sec_tick_o, et);
            chk(cyc_wrap_o == ew, "R8 wrap", cyc_wrap_o, ew);
            if (ew) done = 1;
            k++;
            if (gap > 0) begin
                repeat (gap) @(negedge clk);
                chk(pass_o == 1'b0, "R10 idle pass", pass_o, 0);
                chk(int'(count_o) == exp_cnt, "R10 idle count", count_o, exp_cnt);
            end
        end
        taken = k;
        chk(taken == FULL + cap, req, taken, FULL + cap);
    endtask

    task automatic t_reset_state();
        chk(count_o == '0, "R9 reset count", count_o, 0);
        chk(pass_o == 1'b0, "R9 reset pass", pass_o, 0);
        chk(sec_tick_o == 1'b0 && cyc_wrap_o == 1'b0, "R9 reset strobes",
            {sec_tick_o, cyc_wrap_o}, 0);
    endtask

    task automatic t_zero_trim();
        int n;
        run_cycle(0, -1, 0, 1, "R5 zero trim length", n);
    endtask

    task automatic t_midcycle_change();
        int n;
        run_cycle(9, 300, 40, 0, "R4 old word holds this cycle", n);
        run_cycle(40, -1, 40, 0, "R4 new word next cycle", n);
    endtask

    task automatic t_max_trim();
        int n;
        run_cycle(127, -1, 127, 0, "R6 max trim length", n);
    endtask

    task automatic t_reset_restart();
        int n;
        trim = TW'(20);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); ref_p = 1'b1;
            @(negedge clk); ref_p = 1'b0;
        end
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(count_o == '0, "R9 mid reset count", count_o, 0);
        chk(pass_o == 1'b0, "R9 mid reset pass", pass_o, 0);
        rst = 1'b0;
        exp_cnt = 0;
        run_cycle(3, -1, 3, 0, "R9 R3 restart length", n);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst = 1'b0;
        t_zero_trim();
        t_midcycle_change();
        t_max_trim();
        t_reset_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule